// File: doc/BRIEF.md
# Timer Channel Input Capture with Counter Restart

This block combines a free-running up-counter with one capture channel. The counter begins each run from a programmable start value. It climbs by one per clock and returns to the start value after it reaches a programmable limit.

The channel input comes in asynchronously. It passes through a synchronizer and a glitch filter, and the filtered level is then watched for the edge type that has been selected. When that edge appears, the counter value is latched into a capture register and a sticky flag is set. If the interrupt enable is high, an interrupt request follows from the flag.

With the restart option on, the same edge also reloads the counter with its start value. Each capture then holds the time since the previous one, measured in clocks from the start value, so software can read a period or pulse width with no subtraction. The flag stays set until software pulses the clear input.

Top module: `capture_timer`

## Requirements
- R1: After reset, `count` is 0. On each clock that has no reload and no wrap, `count` rises by exactly 1.
- R2: When `count` equals `mod_val`, the next clock loads `count` with `init_val`.
- R3: A change of `chan_in` is first sampled at some clock edge. The capture happens SYNC_STAGES+FILT_CYC clock edges after that edge (5 with the defaults). `capture_val` then holds the `count` value present just before the capture edge.
- R4: `edge_sel` chooses the capturing edges: 2'b01 captures rising edges only, 2'b10 falling edges only, 2'b11 both, and 2'b00 none. Edges that are not selected change neither `flag` nor `capture_val`.
- R5: A capture sets `flag`. The flag stays at 1 until a clock on which `flag_clr` is 1 and no capture happens. A capture and a clear on the same clock leave `flag` at 1.
- R6: `irq` is 1 exactly when `flag` is 1 and `irq_en` is 1.
- R7: With `reset_on_capture` at 1, `count` equals `init_val` on the cycle after the capture edge, not `init_val`+1. Rising edges P clocks apart then capture `init_val`+P-1.
- R8: With `reset_on_capture` at 0, a capture does not disturb the counter, so `count` is the captured value plus 1 on the next cycle.
- R9: After synchronization, a new input level must persist for FILT_CYC consecutive clocks (3 by default) to be accepted. A 2-clock pulse produces no capture. A 3-clock pulse is accepted.
- R10: During reset, `count`, `capture_val`, `flag` and `irq` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| chan_in | input | 1 | Asynchronous channel input |
| edge_sel | input | 2 | Edge choice: 01 rise, 10 fall, 11 both, 00 none |
| reset_on_capture | input | 1 | Reload the counter with `init_val` on each capture |
| irq_en | input | 1 | Interrupt enable |
| init_val | input | CNT_W | Counter start value |
| mod_val | input | CNT_W | Counter limit value; the counter wraps after it |
| flag_clr | input | 1 | Clear pulse for the capture flag |
| count | output | CNT_W | Current counter value |
| capture_val | output | CNT_W | Last captured counter value |
| flag | output | 1 | Sticky capture flag |
| irq | output | 1 | Interrupt request |

## Verification
The bench measures the capture latency exactly. A design with one register too many or too few in the input path would latch a value off by one from the count the bench sampled.

Period trains run with restart enabled, and the bench expects `init_val`+P-1. A design whose counter resumed at `init_val`+1 would be off by one, and one that ignored the restart would capture a growing value.

The bench sends 2-clock and 3-clock pulses against the filter threshold. It also drives each unselected edge type and the disabled setting, where any stray capture shows up as an unexpected flag.

Finally, a clear pulse is placed on the capture clock itself. A design that gave the clear priority would drop the flag there.

// File: rtl/capt_pkg.sv
// Shared types for the capture timer.
// The edge-select encoding uses bit 0 to enable rising edges and bit 1 to
// enable falling edges; the edge detector decodes it in exactly that way.
package capt_pkg;
    typedef enum logic [1:0] {
        EDGE_NONE = 2'b00,
        EDGE_RISE = 2'b01,
        EDGE_FALL = 2'b10,
        EDGE_BOTH = 2'b11
    } edge_sel_e;
endpackage

// File: rtl/capt_filter.sv
// Input conditioner: an N-stage synchronizer followed by a persistence filter.
// A new synchronized level is accepted once it has differed from the current
// filtered level for FILT_CYC consecutive clocks.
// Assumes SYNC_STAGES >= 2 and FILT_CYC >= 1.
module capt_filter #(
    parameter int SYNC_STAGES = 2,
    parameter int FILT_CYC    = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_in,
    output logic filt_out
);
    localparam int RUN_W = $clog2(FILT_CYC + 1);
    localparam logic [RUN_W-1:0] LAST = RUN_W'(FILT_CYC - 1);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   sampled;
    logic [RUN_W-1:0]       run_q;
    logic                   filt_q;

    // Shift the raw input through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], raw_in};
    end

    assign sampled = sync_q[SYNC_STAGES-1];

    // Count how long the sampled level disagrees, and accept it at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q  <= '0;
            filt_q <= 1'b0;
        end else if (sampled == filt_q) begin
            run_q <= '0;
        end else if (run_q == LAST) begin
            filt_q <= sampled;
            run_q  <= '0;
        end else begin
            run_q <= run_q + RUN_W'(1);
        end
    end

    assign filt_out = filt_q;

    // R9: the filtered level only moves after a full run of disagreement.
    assert_filter_run_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (filt_q != $past(filt_q)) |-> ($past(run_q) == LAST));

    // R9: while the input agrees with the output, the output holds.
    assert_filter_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (sampled == filt_q) |=> (filt_q == $past(filt_q)));
endmodule

// File: rtl/capt_edge.sv
// Edge detector on the filtered input.
// It compares the current filtered level against the level seen one clock
// earlier, and raises a single-cycle event for the edge kinds that edge_sel
// enables. Assumes the filtered input is already synchronous to clk.
module capt_edge
    import capt_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      filt_in,
    input  edge_sel_e sel,
    output logic      evt
);
    logic prev_q;
    logic rise, fall;

    // Remember the previous filtered level.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= filt_in;
    end

    // Decode the selected edge kinds into one capture event.
    always_comb begin
        rise = filt_in & ~prev_q;
        fall = ~filt_in & prev_q;
        evt  = (sel[0] & rise) | (sel[1] & fall);
    end

    // R4: with no edges selected, no event is ever raised.
    assert_no_edge_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == EDGE_NONE) |-> !evt);

    // R4: a rise-only selection never fires on a falling level.
    assert_rise_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == EDGE_RISE && evt) |-> filt_in);
endmodule

// File: rtl/capt_counter.sv
// Free-running up-counter with a programmable start value and limit.
// A reload request takes effect on the same clock, so the next value is the
// start value itself. Assumes init_val and mod_val are held steady while in use.
module capt_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] init_val,
    input  logic [CNT_W-1:0] mod_val,
    input  logic             reload,
    output logic [CNT_W-1:0] count
);
    logic [CNT_W-1:0] count_q;

    // Advance, wrap at the limit, or restart on a reload request.
    always_ff @(posedge clk) begin
        if (!rst_n)                  count_q <= '0;
        else if (reload)             count_q <= init_val;
        else if (count_q == mod_val) count_q <= init_val;
        else                         count_q <= count_q + CNT_W'(1);
    end

    assign count = count_q;

    // R1: a plain clock steps the count by one.
    assert_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!reload && count_q != mod_val) |=> (count_q == $past(count_q) + CNT_W'(1)));

    // R2: reaching the limit returns to the start value.
    assert_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!reload && count_q == mod_val) |=> (count_q == $past(init_val)));

    // R7: a reload lands on the start value, not one past it.
    assert_reload_R7: assert property (@(posedge clk) disable iff (!rst_n)
        reload |=> (count_q == $past(init_val)));
endmodule

// File: rtl/capt_channel.sv
// Capture channel: latches the counter on an event, keeps a sticky flag,
// and forms the interrupt request. A capture outranks a clear on the same clock.
module capt_channel #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cap_evt,
    input  logic [CNT_W-1:0] count_in,
    input  logic             flag_clr,
    input  logic             irq_en,
    output logic [CNT_W-1:0] capture_val,
    output logic             flag,
    output logic             irq
);
    logic [CNT_W-1:0] cap_q;
    logic             flag_q;

    // Latch the counter value on each capture event.
    always_ff @(posedge clk) begin
        if (!rst_n)       cap_q <= '0;
        else if (cap_evt) cap_q <= count_in;
    end

    // Set the flag on capture; a clear only acts when no capture happens.
    always_ff @(posedge clk) begin
        if (!rst_n)        flag_q <= 1'b0;
        else if (cap_evt)  flag_q <= 1'b1;
        else if (flag_clr) flag_q <= 1'b0;
    end

    assign capture_val = cap_q;
    assign flag        = flag_q;
    assign irq         = flag_q & irq_en;

    // R3: the register holds the count seen at the capture edge.
    assert_capture_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cap_evt |=> (cap_q == $past(count_in)));

    // R5: a capture always leaves the flag set, whatever the clear does.
    assert_flag_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cap_evt |=> flag_q);

    // R5: without a clear, the flag never drops.
    assert_flag_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && !flag_clr) |=> flag_q);

    // R3: without an event, the captured value holds.
    assert_capture_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_evt |=> $stable(cap_q));
endmodule

// File: rtl/capture_timer.sv
// Top level: one input-capture channel and the counter it samples.
// The chain is raw input -> synchronizer and filter -> edge detector ->
// capture channel. An optional reload of the counter on every capture lets the
// captured value read directly as a period or pulse width.
module capture_timer
    import capt_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2,
    parameter int FILT_CYC    = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             chan_in,
    input  logic [1:0]       edge_sel,
    input  logic             reset_on_capture,
    input  logic             irq_en,
    input  logic [CNT_W-1:0] init_val,
    input  logic [CNT_W-1:0] mod_val,
    input  logic             flag_clr,
    output logic [CNT_W-1:0] count,
    output logic [CNT_W-1:0] capture_val,
    output logic             flag,
    output logic             irq
);
    logic             filt_lvl;
    logic             cap_evt;
    logic             reload;
    logic [CNT_W-1:0] count_w;

    capt_filter #(.SYNC_STAGES(SYNC_STAGES), .FILT_CYC(FILT_CYC)) u_filter (
        .clk      (clk),
        .rst_n    (rst_n),
        .raw_in   (chan_in),
        .filt_out (filt_lvl)
    );

    capt_edge u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .filt_in (filt_lvl),
        .sel     (edge_sel_e'(edge_sel)),
        .evt     (cap_evt)
    );

    assign reload = cap_evt & reset_on_capture;

    capt_counter #(.CNT_W(CNT_W)) u_counter (
        .clk      (clk),
        .rst_n    (rst_n),
        .init_val (init_val),
        .mod_val  (mod_val),
        .reload   (reload),
        .count    (count_w)
    );

    capt_channel #(.CNT_W(CNT_W)) u_channel (
        .clk         (clk),
        .rst_n       (rst_n),
        .cap_evt     (cap_evt),
        .count_in    (count_w),
        .flag_clr    (flag_clr),
        .irq_en      (irq_en),
        .capture_val (capture_val),
        .flag        (flag),
        .irq         (irq)
    );

    assign count = count_w;

    // R6: an interrupt is never raised while the enable is low.
    assert_irq_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_en |-> !irq);

    // R8: with restart off, a capture edge still steps the counter normally.
    assert_no_reload_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_evt && !reset_on_capture && count_w != mod_val)
        |=> (count_w == $past(count_w) + CNT_W'(1)));
endmodule

// File: tb/capture_timer_test.sv
// Scoreboard bench: driver tasks push expected captures into a queue, and a
// monitor pops them whenever the flag rises and compares capture_val.
module capture_timer_test;
    localparam int CLK_PERIOD = 10;
    localparam int CNT_W      = 16;
    localparam int SYNC       = 2;
    localparam int FILT       = 3;
    localparam int LAT        = SYNC + FILT;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             chan_in;
    logic [1:0]       edge_sel;
    logic             reset_on_capture;
    logic             irq_en;
    logic [CNT_W-1:0] init_val;
    logic [CNT_W-1:0] mod_val;
    logic             flag_clr;
    logic [CNT_W-1:0] count;
    logic [CNT_W-1:0] capture_val;
    logic             flag;
    logic             irq;

    logic             tb_clr  = 1'b0;
    logic             mon_clr = 1'b0;
    logic             auto_clr = 1'b1;
    logic             flag_seen = 1'b0;
    int               checks = 0;
    int               errors = 0;
    logic [CNT_W-1:0] exp_val_q[$];
    int               exp_post_q[$];

    assign flag_clr = tb_clr | mon_clr;

    capture_timer #(.CNT_W(CNT_W), .SYNC_STAGES(SYNC), .FILT_CYC(FILT)) uut (
        .clk              (clk),
        .rst_n            (rst_n),
        .chan_in          (chan_in),
        .edge_sel         (edge_sel),
        .reset_on_capture (reset_on_capture),
        .irq_en           (irq_en),
        .init_val         (init_val),
        .mod_val          (mod_val),
        .flag_clr         (flag_clr),
        .count            (count),
        .capture_val      (capture_val),
        .flag             (flag),
        .irq              (irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Drive one level change; if a capture is expected, push the count sampled
    // just before the capture edge. Otherwise confirm the flag stays low.
    task automatic edge_once(input logic lvl, input bit expect_cap);
        chan_in = lvl;
        tick(LAT);
        if (expect_cap) begin
            exp_val_q.push_back(count);
            exp_post_q.push_back(reset_on_capture ? 1 : 2);
            tick(4);
        end else begin
            tick(1);
            check(flag == 1'b0, "R4", "unselected edge set flag", flag, 0);
            tick(3);
        end
    endtask

    // Rising edges every P clocks with restart on; later captures are init+P-1 (R7).
    task automatic pulse_train(input int p, input int n);
        for (int i = 0; i < n; i++) begin
            chan_in = 1'b1;
            tick(LAT);
            if (i == 0) exp_val_q.push_back(count);
            else        exp_val_q.push_back(init_val + CNT_W'(p - 1));
            exp_post_q.push_back(1);
            tick(p/2 - LAT);
            chan_in = 1'b0;
            tick(p - p/2);
        end
    endtask

    // Monitor: pop an expected item on each rising flag and compare.
    always @(negedge clk) begin
        mon_clr = 1'b0;
        if (rst_n && flag && !flag_seen) begin
            if (exp_val_q.size() == 0) begin
                check(1'b0, "R4", "unexpected capture", int'(capture_val), 0);
            end else begin
                automatic logic [CNT_W-1:0] ev = exp_val_q.pop_front();
                automatic int               ep = exp_post_q.pop_front();
                check(capture_val == ev, "R3", "captured value", int'(capture_val), int'(ev));
                if (ep == 1)
                    check(count == init_val, "R7", "count after restart", int'(count), int'(init_val));
                else
                    check(count == ev + CNT_W'(1), "R8", "count after capture", int'(count), int'(ev) + 1);
            end
            if (auto_clr) mon_clr = 1'b1;
        end
        flag_seen = flag;
    end

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        tick(200000 - 1000);
        check(1'b0, "R1", "watchdog expired", 0, 1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0; chan_in = 1'b0; edge_sel = 2'b01; reset_on_capture = 1'b0;
        irq_en = 1'b0; init_val = 16'd0; mod_val = 16'd60000;
        tick(3);
        // R10: reset state
        check(count == 0, "R10", "count in reset", int'(count), 0);
        check(capture_val == 0, "R10", "capture_val in reset", int'(capture_val), 0);
        check(flag == 0 && irq == 0, "R10", "flag/irq in reset", {flag, irq}, 0);
        rst_n = 1'b1;
        tick(3);
        check(count == 3, "R1", "count three clocks after reset", int'(count), 3);

        // R1 R2: stepping and wrap with init=5, limit=20
        init_val = 16'd5; mod_val = 16'd20;
        for (int i = 0; i < 40; i++) begin
            automatic logic [CNT_W-1:0] prev = count;
            tick(1);
            if (prev == mod_val)
                check(count == init_val, "R2", "wrap to start", int'(count), int'(init_val));
            else
                check(count == prev + 16'd1, "R1", "step by one", int'(count), int'(prev) + 1);
        end

        // R3 R4 R8: rising only, restart off
        init_val = 16'd100; mod_val = 16'd60000;
        edge_sel = 2'b01;
        edge_once(1'b1, 1'b1);
        edge_once(1'b0, 1'b0);
        edge_once(1'b1, 1'b1);
        edge_once(1'b0, 1'b0);

        // R4: falling only
        edge_sel = 2'b10;
        edge_once(1'b1, 1'b0);
        edge_once(1'b0, 1'b1);

        // R4: both edges
        edge_sel = 2'b11;
        edge_once(1'b1, 1'b1);
        edge_once(1'b0, 1'b1);

        // R4: no edges
        edge_sel = 2'b00;
        edge_once(1'b1, 1'b0);
        edge_once(1'b0, 1'b0);

        // R7: period measurement with restart on
        edge_sel = 2'b01; reset_on_capture = 1'b1; init_val = 16'd7;
        pulse_train(10, 3);
        pulse_train(16, 3);
        reset_on_capture = 1'b0;

        // R9: a 2-clock pulse is rejected, a 3-clock pulse is accepted
        chan_in = 1'b1; tick(2); chan_in = 1'b0; tick(LAT + 4);
        check(flag == 0, "R9", "short pulse captured", flag, 0);
        chan_in = 1'b1; tick(3); chan_in = 1'b0; tick(LAT - 3);
        exp_val_q.push_back(count); exp_post_q.push_back(2);
        tick(6);

        // R5 R6: sticky flag, interrupt gating, clear versus capture
        auto_clr = 1'b0;
        edge_once(1'b1, 1'b1);
        check(flag == 1, "R5", "flag after capture", flag, 1);
        check(irq == 0, "R6", "irq with enable low", irq, 0);
        tick(5);
        check(flag == 1, "R5", "flag held", flag, 1);
        irq_en = 1'b1; tick(1);
        check(irq == 1, "R6", "irq with enable high", irq, 1);
        tb_clr = 1'b1; tick(1); tb_clr = 1'b0;
        check(flag == 0, "R5", "flag cleared", flag, 0);
        check(irq == 0, "R6", "irq after clear", irq, 0);
        chan_in = 1'b0; tick(LAT + 3);
        edge_once(1'b1, 1'b1);
        chan_in = 1'b0; tick(LAT + 3);
        begin
            automatic logic [CNT_W-1:0] smp;
            chan_in = 1'b1; tick(LAT);
            smp = count;
            tb_clr = 1'b1; tick(1); tb_clr = 1'b0;
            check(flag == 1, "R5", "capture beats clear", flag, 1);
            check(capture_val == smp, "R3", "value with clear", int'(capture_val), int'(smp));
        end
        tick(3);
        check(exp_val_q.size() == 0, "R3", "missing captures", exp_val_q.size(), 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule